// File: doc/BRIEF.md
# Partitioned SIMD Compare Unit

This unit compares two 64-bit words piece by piece. Each piece, or lane, is a signed two's-complement integer. The word can be cut into four 16-bit lanes or into two 32-bit lanes. The unit tests one condition on every lane and gathers the per-lane outcomes into a small bitmask. That mask is zero-extended to a full 64-bit result word. A 3-bit mode input picks both the lane width and the condition.

Operands enter on a valid/ready stream, and results leave on a second valid/ready stream through a single register stage. An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` on the following cycle. The output register holds its value while the consumer keeps `out_ready` low. During that time `in_ready` is low, so no new operands are taken until the held result is consumed. When the result is taken, a new pair may be accepted on the same edge.

Top module: `psc_unit`

## Requirements
- R1: With mode bit 2 at 0 the operands are split into four 16-bit lanes, and with mode bit 2 at 1 into two 32-bit lanes. Lane i occupies bits starting at i times the lane width.
- R2: Every lane comparison treats both lanes as signed two's-complement values, first operand against second. For example, 16'h8000 is less than 16'h0001.
- R3: Mode bits 1:0 select the condition: 00 first > second, 01 first <= second, 10 first != second, 11 first == second.
- R4: In 16-bit mode a true result in lane i sets result bit (3 - i), so lane 0 drives bit 3 and lane 3 drives bit 0.
- R5: In 32-bit mode a true result in lane i sets result bit (1 - i), so lane 0 drives bit 1 and lane 1 drives bit 0.
- R6: A 32-bit lane is compared on all 32 of its bits. Lanes whose low halves match but whose high halves differ compare as unequal, and they are ordered by their full signed value.
- R7: Result bits 63:4 are zero in 16-bit mode, and result bits 63:2 are zero in 32-bit mode.
- R8: `out_valid` is high on the cycle after an accepted input. While `out_valid` is high and `out_ready` is low, `out_data` holds its value and `in_ready` is low. Otherwise `in_ready` is high.
- R9: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair and mode are valid |
| in_ready | output | 1 | Unit can accept an operand pair |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_mode | input | 3 | Bit 2 selects the lane width, bits 1:0 select the condition |
| out_valid | output | 1 | Result word is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64 | Zero-extended lane mask |

## Verification
The hardest outcomes to reach from the ports are those where the sign and the width of a lane interact. Two such cases are equal most-negative lanes and a negative lane compared with a positive one. A third is a pair of 32-bit lanes that differ only in their upper half, which a truncating compare would wrongly report as equal. The bench builds operands that isolate each of these in a single lane while every other lane stays equal, so a misplaced or reversed mask bit shows at once. It also stalls the consumer while a second operand pair waits at the input, so that holding the result and the same-edge hand-over are both observed.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int MODE_W = 3;
  localparam int NARROW_W = 16;
  localparam int WIDE_W = 32;

  typedef enum logic [1:0] {
    COND_GT = 2'b00,
    COND_LE = 2'b01,
    COND_NE = 2'b10,
    COND_EQ = 2'b11
  } cond_e;

  typedef enum logic {
    LW_NARROW = 1'b0,
    LW_WIDE   = 1'b1
  } lwidth_e;

  // Reduce a signed greater-than flag and an equality flag to the chosen condition.
  function automatic logic cond_hit(cond_e c, logic gt, logic eq);
    logic r;
    case (c)
      COND_GT: r = gt;
      COND_LE: r = ~gt;
      COND_NE: r = ~eq;
      default: r = eq;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/psc_lane_cmp.sv
module psc_lane_cmp
  import psc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  cond_e        cond,
  output logic         hit
);
  logic gt;
  logic eq;

  always_comb begin
    gt  = $signed(a) > $signed(b);
    eq  = (a == b);
    hit = cond_hit(cond, gt, eq);
  end
endmodule

// File: rtl/psc_mask_pack.sv
module psc_mask_pack #(
  parameter int LANES  = 4,
  parameter int DATA_W = 64
) (
  input  logic [LANES-1:0]  hits,
  output logic [DATA_W-1:0] word
);
  logic [LANES-1:0] rev;

  // The lowest lane drives the highest mask bit.
  for (genvar i = 0; i < LANES; i++) begin : g_rev
    assign rev[LANES-1-i] = hits[i];
  end

  assign word = {{(DATA_W-LANES){1'b0}}, rev};
endmodule

// File: rtl/psc_unit.sv
module psc_unit
  import psc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [MODE_W-1:0] in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int N_NARROW = DATA_W / NARROW_W;
  localparam int N_WIDE   = DATA_W / WIDE_W;

  cond_e   cond;
  lwidth_e lw;
  assign cond = cond_e'(in_mode[1:0]);
  assign lw   = lwidth_e'(in_mode[2]);

  logic [N_NARROW-1:0] hit_n;
  logic [N_WIDE-1:0]   hit_w;
  logic [DATA_W-1:0]   word_n;
  logic [DATA_W-1:0]   word_w;
  logic [DATA_W-1:0]   word_sel;

  for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
    psc_lane_cmp #(.W(NARROW_W)) u_cmp (
      .a   (in_a[i*NARROW_W +: NARROW_W]),
      .b   (in_b[i*NARROW_W +: NARROW_W]),
      .cond(cond),
      .hit (hit_n[i])
    );
  end

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    psc_lane_cmp #(.W(WIDE_W)) u_cmp (
      .a   (in_a[i*WIDE_W +: WIDE_W]),
      .b   (in_b[i*WIDE_W +: WIDE_W]),
      .cond(cond),
      .hit (hit_w[i])
    );
  end

  psc_mask_pack #(.LANES(N_NARROW), .DATA_W(DATA_W)) u_pack_n (
    .hits(hit_n),
    .word(word_n)
  );

  psc_mask_pack #(.LANES(N_WIDE), .DATA_W(DATA_W)) u_pack_w (
    .hits(hit_w),
    .word(word_w)
  );

  assign word_sel = (lw == LW_WIDE) ? word_w : word_n;

  // One output register with a skid-free valid/ready hand-over.
  logic accept;
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
    end else if (accept) begin
      out_data <= word_sel;
    end
  end
endmodule

// File: rtl/psc_unit_chk.sv
module psc_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [2:0]        in_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> !out_valid); // R9

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[DATA_W-1:4] == '0)); // R7

  AST_WIDE_NARROW_MASK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode[2]) |=> (out_data[3:2] == 2'b00)); // R5

  AST_EQ_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode == 3'b011 && in_a == in_b)
      |=> (out_data[3:0] == 4'hF)); // R3
endmodule

bind psc_unit psc_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_psc_unit.sv
`timescale 1ns/1ps
module tb_psc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic [2:0]  in_mode;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  psc_unit dut (.*);

  // Expected result built from the requirements.
  function automatic logic [63:0] expect_word(logic [63:0] a, logic [63:0] b, logic [2:0] m);
    logic [63:0] r = '0;
    if (!m[2]) begin
      for (int i = 0; i < 4; i++) begin
        logic signed [15:0] x = a[16*i +: 16];
        logic signed [15:0] y = b[16*i +: 16];
        logic c;
        case (m[1:0])
          2'b00: c = x > y;
          2'b01: c = x <= y;
          2'b10: c = x != y;
          default: c = x == y;
        endcase
        r[3-i] = c;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic signed [31:0] x = a[32*i +: 32];
        logic signed [31:0] y = b[32*i +: 32];
        logic c;
        case (m[1:0])
          2'b00: c = x > y;
          2'b01: c = x <= y;
          2'b10: c = x != y;
          default: c = x == y;
        endcase
        r[1-i] = c;
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One transaction with the consumer ready; the result is checked one cycle later.
  task automatic xact(string req, logic [63:0] a, logic [63:0] b, logic [2:0] m, logic [63:0] exp);
    @(negedge clk);
    in_a = a; in_b = b; in_mode = m; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check(req, out_data, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_a = '0; in_b = '0; in_mode = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    check("R8 ready after reset", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_conds16;
    logic [63:0] a = {16'hFFFF, 16'd5, 16'd7, 16'd100};
    logic [63:0] b = {16'd3,    16'd5, 16'd9, 16'hFF00};
    for (int c = 0; c < 4; c++)
      xact("R1 R3 narrow conds", a, b, {1'b0, 2'(c)}, expect_word(a, b, {1'b0, 2'(c)}));
    // lane3 -1>3 no, lane2 eq, lane1 7>9 no, lane0 100>-256 yes -> GT = 1000
    xact("R3 GT narrow literal", a, b, 3'b000, 64'h8);
  endtask

  task automatic t_order16;
    xact("R4 lane0 to bit3", 64'h0000_0000_0000_0001, 64'h0, 3'b010, 64'h8);
    xact("R4 lane3 to bit0", 64'h0001_0000_0000_0000, 64'h0, 3'b010, 64'h1);
    xact("R7 narrow upper zero EQ", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 3'b011, 64'hF);
  endtask

  task automatic t_order32;
    xact("R5 lane0 to bit1", 64'h0000_0000_0000_0001, 64'h0, 3'b110, 64'h2);
    xact("R5 lane1 to bit0", 64'h0000_0001_0000_0000, 64'h0, 3'b110, 64'h1);
    xact("R7 wide upper zero EQ", 64'hDEAD_BEEF_0BAD_F00D, 64'hDEAD_BEEF_0BAD_F00D, 3'b111, 64'h3);
  endtask

  task automatic t_signed;
    xact("R2 min vs one GT", 64'h8000, 64'h0001, 3'b000, 64'h0);
    xact("R2 min vs one LE", 64'h8000, 64'h0001, 3'b001, 64'hF);
    xact("R2 equal min EQ", 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 3'b011, 64'hF);
    xact("R2 wide neg vs pos GT", 64'h0000_0001_8000_0000, 64'h0000_0000_7FFF_FFFF, 3'b100, 64'h1);
  endtask

  task automatic t_full32;
    xact("R6 high half differs NE", 64'h0001_0005, 64'h0002_0005, 3'b110, 64'h2);
    xact("R6 high half differs EQ", 64'h0001_0005, 64'h0002_0005, 3'b111, 64'h1);
    xact("R6 high half differs GT", 64'h0003_0005, 64'h0002_0005, 3'b100, 64'h2);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 64'h1; in_b = 64'h0; in_mode = 3'b000; in_valid = 1'b1;
    @(negedge clk);
    check("R8 stall valid", {63'd0, out_valid}, 64'd1);
    check("R8 stall ready low", {63'd0, in_ready}, 64'd0);
    in_a = 64'h0; in_b = 64'h0; in_mode = 3'b011;
    @(negedge clk);
    check("R8 stall hold data", out_data, 64'h8);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 hand-over data", out_data, 64'hF);
    @(negedge clk);
    check("R8 drain valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 64'h5; in_b = 64'h5; in_mode = 3'b011; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid reset clears valid", {63'd0, out_valid}, 64'd0);
    out_ready = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_conds16();
    t_order16();
    t_order32();
    t_signed();
    t_full32();
    t_backpressure();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule